// File: doc/BRIEF.md
# Load-Balanced Round-Robin Crossbar

This block is the switching core of a two-stage load-balanced switch. A frame has N slots of one clock each. A slot counter advances every cycle and, through a fixed cyclic permutation, connects every port to exactly one partner in each slot. Over one frame, each port meets every other port exactly once. No scheduler and no arbitration are involved.

The same connection pattern serves two passes in the same cycle. In the spreading pass, each input hands its presented cell to the port it is connected to in that slot, whatever the cell's destination. That port, acting as an intermediate, files the cell into one of N per-destination queues. In the delivery pass, each intermediate port looks at the queue for the output it is connected to in that slot. If the queue holds a cell, the intermediate port forwards the oldest one. If the queue is empty, it sends nothing.

Because one fabric carries both passes, each connection carries up to two cells per slot: one spread cell and one delivered cell. Ports are numbered from 0.

Top module: `lb_rr_xbar`

## Requirements
- R1: While `rst_n` is low, and before the first clock after its release, `slot` is 0, every `out_valid` bit is 0, every drop counter is 0 and every queue is empty.
- R2: `slot` advances by one on every clock and wraps from N_PORTS−1 to 0.
- R3: In slot t, transmitting port k is connected to receiving port (t − k) mod N_PORTS. Each slot's map is a bijection, so every transmitter meets every receiver exactly once per frame.
- R4: A valid cell at input i in slot t is stored at intermediate port m = (t − i) mod N_PORTS, in that port's queue numbered by the cell's `in_dest` field. The destination plays no part in choosing m.
- R5: In slot t, intermediate port m forwards the oldest cell of its queue o = (t − m) mod N_PORTS to output o. That cell appears on `out_data[o]` with `out_valid[o]` = 1 one clock later. Each queue keeps first-in first-out order.
- R6: When the queue selected for an output is empty, that output's `out_valid` is 0 in the following cycle. Idle cycles are not deliveries.
- R7: A cell that arrives for a queue already holding VOQ_DEPTH cells is discarded, and the receiving intermediate port's `drop_cnt` rises by one. Fullness is judged on the occupancy before that clock's delivery.
- R8: A cell with `in_valid` = 0 has no effect: nothing is stored, nothing is delivered because of it, and no counter moves.
- R9: A cell stored into an empty queue in the same slot in which that queue is selected for delivery is not forwarded in that slot. It waits until the queue is next selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N_PORTS | Per-input cell-present flag |
| in_data | input | N_PORTS×DATA_W | Per-input cell payload |
| in_dest | input | N_PORTS×SLOT_W | Per-input destination output number |
| out_valid | output | N_PORTS | Per-output delivered-cell flag |
| out_data | output | N_PORTS×DATA_W | Per-output delivered payload |
| drop_cnt | output | N_PORTS×CNT_W | Per-intermediate-port count of discarded cells |
| slot | output | SLOT_W | Current slot number |

## Verification
The bench drives the block with several patterns:
- Long idle stretches carrying random data with the valid bits low. These show that invalid cells leave no trace and that the slot wrap is correct.
- A sparse random mix. This exposes any error in which intermediate port or queue a cell reaches.
- Uniform heavy random traffic. This tests queue ordering under steady contention.
- A hotspot pattern with every input aimed at output 0. This fills queues and separates a correct drop decision from one that counts the same-cycle delivery.
- A pattern where each input targets its own index. This lands every cell in the very queue being served in that slot, which isolates the same-slot push and pop case.

// File: rtl/lbx_pkg.sv
package lbx_pkg;

    // Partner of port k in slot t on an n-port cyclic Latin square
    function automatic int conn_of(int t, int k, int n);
        return (t + n - k) % n;
    endfunction

endpackage

// File: rtl/lbx_slot_sched.sv
module lbx_slot_sched #(
    parameter int N_PORTS = 4,
    parameter int SLOT_W  = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    output logic [SLOT_W-1:0]               slot_o,
    output logic [N_PORTS-1:0][SLOT_W-1:0]  conn_o
);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
    } sched_t;

    sched_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (s_q.slot == SLOT_W'(N_PORTS - 1)) begin
            s_d.slot = '0;
        end else begin
            s_d.slot = s_q.slot + SLOT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign slot_o = s_q.slot;

    // Connection map is purely combinational from the slot number
    always_comb begin
        for (int k = 0; k < N_PORTS; k++) begin
            conn_o[k] = SLOT_W'(lbx_pkg::conn_of(int'(s_q.slot), k, N_PORTS));
        end
    end

    // Receivers covered in this slot, for the bijection check
    logic [N_PORTS-1:0] hit;
    always_comb begin
        hit = '0;
        for (int k = 0; k < N_PORTS; k++) begin
            hit[conn_o[k]] = 1'b1;
        end
    end

    p_slot_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_o == SLOT_W'(N_PORTS - 1)) |=> (slot_o == '0));

    p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_o != SLOT_W'(N_PORTS - 1)) |=> (slot_o == $past(slot_o) + SLOT_W'(1)));

    p_perm_bijective_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (&hit));

endmodule

// File: rtl/lbx_voq_bank.sv
module lbx_voq_bank #(
    parameter int N_PORTS   = 4,
    parameter int DATA_W    = 8,
    parameter int VOQ_DEPTH = 4,
    parameter int CNT_W     = 16,
    parameter int SLOT_W    = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_vld,
    input  logic [SLOT_W-1:0] push_dest,
    input  logic [DATA_W-1:0] push_data,
    input  logic [SLOT_W-1:0] pop_sel,
    output logic              pop_vld,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  drop_cnt
);

    localparam int PTR_W = (VOQ_DEPTH > 1) ? $clog2(VOQ_DEPTH) : 1;
    localparam int OCC_W = $clog2(VOQ_DEPTH + 1);

    typedef struct packed {
        logic [N_PORTS-1:0][VOQ_DEPTH-1:0][DATA_W-1:0] mem;
        logic [N_PORTS-1:0][PTR_W-1:0]                 head;
        logic [N_PORTS-1:0][OCC_W-1:0]                 occ;
        logic [CNT_W-1:0]                              drops;
    } bank_t;

    bank_t b_q, b_d;
    logic              is_full;
    logic [PTR_W-1:0]  tail;

    always_comb begin
        b_d      = b_q;
        pop_vld  = (b_q.occ[pop_sel] != '0);
        pop_data = b_q.mem[pop_sel][b_q.head[pop_sel]];
        // Fullness uses the occupancy before this cycle's delivery
        is_full  = (b_q.occ[push_dest] == OCC_W'(VOQ_DEPTH));
        tail     = PTR_W'((int'(b_q.head[push_dest]) + int'(b_q.occ[push_dest])) % VOQ_DEPTH);

        if (pop_vld) begin
            if (b_q.head[pop_sel] == PTR_W'(VOQ_DEPTH - 1)) begin
                b_d.head[pop_sel] = '0;
            end else begin
                b_d.head[pop_sel] = b_q.head[pop_sel] + PTR_W'(1);
            end
            b_d.occ[pop_sel] = b_q.occ[pop_sel] - OCC_W'(1);
        end

        if (push_vld) begin
            if (is_full) begin
                b_d.drops = b_q.drops + CNT_W'(1);
            end else begin
                b_d.mem[push_dest][tail] = push_data;
                b_d.occ[push_dest]       = b_d.occ[push_dest] + OCC_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign drop_cnt = b_q.drops;

    for (genvar k = 0; k < N_PORTS; k++) begin : g_occ_chk
        p_occ_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (b_q.occ[k] <= OCC_W'(VOQ_DEPTH)));
    end

    p_drop_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_vld && is_full) |=> (drop_cnt == $past(drop_cnt) + CNT_W'(1)));

    p_drop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_vld && is_full) |=> $stable(drop_cnt));

endmodule

// File: rtl/lb_rr_xbar.sv
module lb_rr_xbar #(
    parameter int N_PORTS   = 4,
    parameter int DATA_W    = 8,
    parameter int VOQ_DEPTH = 4,
    parameter int CNT_W     = 16,
    localparam int SLOT_W   = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [N_PORTS-1:0]                in_valid,
    input  logic [N_PORTS-1:0][DATA_W-1:0]    in_data,
    input  logic [N_PORTS-1:0][SLOT_W-1:0]    in_dest,
    output logic [N_PORTS-1:0]                out_valid,
    output logic [N_PORTS-1:0][DATA_W-1:0]    out_data,
    output logic [N_PORTS-1:0][CNT_W-1:0]     drop_cnt,
    output logic [SLOT_W-1:0]                 slot
);

    logic [N_PORTS-1:0][SLOT_W-1:0] conn;

    lbx_slot_sched #(
        .N_PORTS (N_PORTS),
        .SLOT_W  (SLOT_W)
    ) u_sched (
        .clk    (clk),
        .rst_n  (rst_n),
        .slot_o (slot),
        .conn_o (conn)
    );

    // Spreading pass: intermediate m hears from input conn[m]
    logic [N_PORTS-1:0]             push_vld;
    logic [N_PORTS-1:0][SLOT_W-1:0] push_dest;
    logic [N_PORTS-1:0][DATA_W-1:0] push_data;
    logic [N_PORTS-1:0]             pop_vld;
    logic [N_PORTS-1:0][DATA_W-1:0] pop_data;

    always_comb begin
        for (int m = 0; m < N_PORTS; m++) begin
            push_vld[m]  = in_valid[conn[m]];
            push_dest[m] = in_dest[conn[m]];
            push_data[m] = in_data[conn[m]];
        end
    end

    for (genvar m = 0; m < N_PORTS; m++) begin : g_bank
        lbx_voq_bank #(
            .N_PORTS   (N_PORTS),
            .DATA_W    (DATA_W),
            .VOQ_DEPTH (VOQ_DEPTH),
            .CNT_W     (CNT_W),
            .SLOT_W    (SLOT_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .push_vld  (push_vld[m]),
            .push_dest (push_dest[m]),
            .push_data (push_data[m]),
            .pop_sel   (conn[m]),
            .pop_vld   (pop_vld[m]),
            .pop_data  (pop_data[m]),
            .drop_cnt  (drop_cnt[m])
        );
    end

    // Delivery pass: output o is fed by intermediate conn[o]
    typedef struct packed {
        logic [N_PORTS-1:0]             vld;
        logic [N_PORTS-1:0][DATA_W-1:0] data;
    } out_t;

    out_t o_q, o_d;

    always_comb begin
        o_d = o_q;
        for (int o = 0; o < N_PORTS; o++) begin
            o_d.vld[o]  = pop_vld[conn[o]];
            o_d.data[o] = pop_data[conn[o]];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid = o_q.vld;
    assign out_data  = o_q.data;

    for (genvar o = 0; o < N_PORTS; o++) begin : g_out_chk
        p_out_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !pop_vld[conn[o]] |=> !out_valid[o]);
    end

endmodule

// File: tb/lb_rr_xbar_tb_top.sv
`timescale 1ns/1ps
module lb_rr_xbar_tb_top;

    localparam int N     = 4;
    localparam int DW    = 8;
    localparam int DEPTH = 4;
    localparam int CW    = 16;
    localparam int SW    = 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                  rst_n;
    logic [N-1:0]          in_valid;
    logic [N-1:0][DW-1:0]  in_data;
    logic [N-1:0][SW-1:0]  in_dest;
    logic [N-1:0]          out_valid;
    logic [N-1:0][DW-1:0]  out_data;
    logic [N-1:0][CW-1:0]  drop_cnt;
    logic [SW-1:0]         slot;

    lb_rr_xbar #(.N_PORTS(N), .DATA_W(DW), .VOQ_DEPTH(DEPTH), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_dest(in_dest), .out_valid(out_valid), .out_data(out_data),
        .drop_cnt(drop_cnt), .slot(slot)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    string tag = "R1";

    // Reference model
    logic [DW-1:0] mq [N][N][$];
    int            m_slot;
    logic [N-1:0]  e_v;
    logic [DW-1:0] e_d [N];
    int            e_drop [N];
    logic [DW-1:0] seq = 8'd1;

    task automatic chk(bit ok, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(int'(slot) == m_slot, "R2 slot", int'(slot), m_slot);
        for (int o = 0; o < N; o++) begin
            chk(out_valid[o] == e_v[o], $sformatf("R5/R6 out_valid[%0d]", o),
                int'(out_valid[o]), int'(e_v[o]));
            if (e_v[o]) begin
                chk(out_data[o] == e_d[o], $sformatf("R5 out_data[%0d]", o),
                    int'(out_data[o]), int'(e_d[o]));
            end
            chk(int'(drop_cnt[o]) == e_drop[o], $sformatf("R7 drop_cnt[%0d]", o),
                int'(drop_cnt[o]), e_drop[o]);
        end
    endtask

    task automatic model_step();
        bit acc [N];
        int tgt [N];
        for (int i = 0; i < N; i++) begin
            acc[i] = 0;
            tgt[i] = (m_slot + N - i) % N;
            if (in_valid[i]) begin
                if (mq[tgt[i]][in_dest[i]].size() >= DEPTH) e_drop[tgt[i]]++;
                else acc[i] = 1;
            end
        end
        for (int o = 0; o < N; o++) begin
            int m = (m_slot + N - o) % N;
            if (mq[m][o].size() > 0) begin
                e_v[o] = 1'b1;
                e_d[o] = mq[m][o].pop_front();
            end else begin
                e_v[o] = 1'b0;
            end
        end
        for (int i = 0; i < N; i++) begin
            if (acc[i]) mq[tgt[i]][in_dest[i]].push_back(in_data[i]);
        end
        m_slot = (m_slot + 1) % N;
    endtask

    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    // pct: chance of valid per input; hot >= 0 forces that destination; own forces dest = index
    task automatic drive(int pct, int hot, bit own);
        for (int i = 0; i < N; i++) begin
            in_valid[i] = (($urandom % 100) < pct);
            in_data[i]  = in_valid[i] ? seq : DW'($urandom);
            if (in_valid[i]) seq = seq + 8'd1;
            if (own)           in_dest[i] = SW'(i);
            else if (hot >= 0) in_dest[i] = SW'(hot);
            else               in_dest[i] = SW'($urandom);
        end
    endtask

    task automatic run(int cycles, int pct, int hot, bit own);
        for (int c = 0; c < cycles; c++) begin
            drive(pct, hot, own);
            cycle();
        end
    endtask

    initial begin
        rst_n = 1'b0; in_valid = '0; in_data = '0; in_dest = '0;
        m_slot = 0; e_v = '0;
        for (int i = 0; i < N; i++) begin e_drop[i] = 0; e_d[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        tag = "R1";
        chk(slot == '0, "R1 slot", int'(slot), 0);
        chk(out_valid == '0, "R1 out_valid", int'(out_valid), 0);
        for (int i = 0; i < N; i++) chk(drop_cnt[i] == '0, "R1 drop_cnt", int'(drop_cnt[i]), 0);
        rst_n = 1'b1;
        tag = "R8"; run(3 * N + 1, 0, -1, 0);     // R8 and R2 wrap
        tag = "R3"; run(40, 20, -1, 0);           // R3/R4 sparse placement
        tag = "R5"; run(300, 70, -1, 0);          // R5 uniform load
        tag = "R7"; run(60, 100, 0, 0);           // R7 hotspot overflow
        tag = "R6"; run(40, 0, -1, 0);            // R6 drain to idle
        tag = "R9"; run(30, 100, -1, 1);          // R9 same-slot push into served queue
        tag = "R6"; run(40, 0, -1, 0);
        tag = "R4"; run(200, 50, -1, 0);          // R4 mixed
        tag = "R6"; run(40, 0, -1, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule